// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is the control core of a synthesizable model of an extended-data-out DRAM. A fast oversampling clock samples the four active-low strobes: row, column, write enable and output enable. The block recovers the order of their edges and uses that order to classify every row cycle. It selects the row that the cycle refreshes and keeps the internal refresh row counter. It also drives the data-output enable by the extended-data-out rules and flags each write as either early or read-write. The storage array is outside this block. It is attached to the outputs.

Each falling edge of the row strobe produces a one-cycle `cycleValid` pulse. With the pulse come an encoded cycle kind and the row to refresh. That row is either the supplied row address or the internal counter value. A test input makes the counter visible so that its increment and wrap behaviour can be observed.

Top module: `dram_strobe_decoder`

## Requirements
- R1: While `rstN` is low and after its release, with all strobes high, `cycleValid`, `driveEn` and `writeValid` are 0, `refreshRow` is 0 and the refresh counter is 0.
- R2: A row strobe fall while the column strobe is high gives one `cycleValid` pulse with `cycleKind` 0 and `refreshRow` equal to `rowAddr`. The counter is not changed.
- R3: A row strobe fall while the column strobe is already low, where the column strobe fell during row precharge, gives `cycleKind` 1. `refreshRow` then equals the counter value before the pulse, and the counter advances by one.
- R4: The column strobe may fall during a row-low access and then stay low while the row strobe rises and falls again. The second fall gives `cycleKind` 2 with the counter row and advances the counter. `driveEn` stays 1 throughout with output enable low.
- R5: A column fall while the row strobe is low and write enable is high is a read. It sets `driveEn` to 1 with output enable low. `driveEn` stays 1 after the column strobe rises, and it drops once both the row and column strobes are high.
- R6: Output enable high forces `driveEn` to 0. Returning it low restores `driveEn` while read data is still held.
- R7: Write enable low at the column fall is an early write. It gives a `writeValid` pulse with `writeLate` 0 and keeps `driveEn` at 0.
- R8: Write enable falling after a read column fall, with both strobes low, gives a `writeValid` pulse with `writeLate` 1. `driveEn` stays 1.
- R9: A row cycle with no column fall never sets `driveEn`.
- R10: The counter runs from 0 to `REFRESH_ROWS`-1 and wraps to 0. `REFRESH_ROWS` is 2048 by default and may be set to 4096.
- R11: `counterView` equals the counter when `testMode` is 1 and is 0 when `testMode` is 0.
- R12: A strobe change appears at the registered outputs on the third rising clock edge after it, with the default two synchronizer stages. `cycleKind` 3 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rowStrobeN | input | 1 | Row strobe, active low |
| colStrobeN | input | 1 | Column strobe, active low |
| writeEnN | input | 1 | Write enable, active low |
| outEnN | input | 1 | Output enable, active low |
| rowAddr | input | log2(REFRESH_ROWS) | Externally supplied row address |
| testMode | input | 1 | Show the refresh counter on `counterView` |
| cycleValid | output | 1 | One-cycle pulse on each row strobe fall |
| cycleKind | output | 2 | 0 addressed, 1 column-before-row, 2 hidden |
| refreshRow | output | log2(REFRESH_ROWS) | Row refreshed by the latest cycle |
| driveEn | output | 1 | Data output driver enable |
| writeValid | output | 1 | One-cycle pulse when a write is recognised |
| writeLate | output | 1 | 1 for read-write, 0 for early write |
| counterView | output | log2(REFRESH_ROWS) | Refresh counter in test mode, else 0 |

## Verification
The corner cases the bench targets are a column strobe that is low at the row fall but got there by different routes. A design that ignored that history would call a hidden refresh a column-before-row refresh, or the reverse, and would also lose the held read data. The bench checks that the output driver stays on after the column strobe rises and turns off only on the later of the two rising edges. A design that turned it off at the column rise, or kept it on past the row rise, would fail those checks. Early writes and read-write cycles are separated by when write enable falls, and a swapped decision shows up on `writeLate` and `driveEn`. The counter is stepped up to its last row and across the wrap, which catches off-by-one limits.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

  localparam int STROBE_W = 4;
  localparam int IDX_ROW  = 0;
  localparam int IDX_COL  = 1;
  localparam int IDX_WE   = 2;
  localparam int IDX_OE   = 3;

  typedef enum logic [1:0] {
    KIND_ADDR   = 2'd0,
    KIND_CBR    = 2'd1,
    KIND_HIDDEN = 2'd2
  } cycleKind_e;

  typedef struct packed {
    logic latchRow;
    logic useCounter;
  } rowCtrl_t;

endpackage

// File: rtl/dram_sync_chain.sv
module dram_sync_chain #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= RESET_VAL;
    else       stage[0] <= dIn;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) stage[g] <= RESET_VAL;
      else       stage[g] <= stage[g-1];
    end
  end

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
  import dram_dec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rowStrobeN,
  input  logic       colStrobeN,
  input  logic       writeEnN,
  input  logic       outEnN,
  output rowCtrl_t   rowCtrl,
  output logic       cycleValid,
  output logic [1:0] cycleKind,
  output logic       driveEn,
  output logic       writeValid,
  output logic       writeLate
);

  logic [STROBE_W-1:0] rawStrobes, syncStrobes, prevStrobes;

  assign rawStrobes = {outEnN, writeEnN, colStrobeN, rowStrobeN};

  dram_sync_chain #(
    .WIDTH(STROBE_W),
    .STAGES(SYNC_STAGES),
    .RESET_VAL({STROBE_W{1'b1}})
  ) uStrobeSync (
    .clk(clk),
    .rstN(rstN),
    .dIn(rawStrobes),
    .dOut(syncStrobes)
  );

  logic rowLow, colLow, weLow, oeLow;
  logic rowFall, colFall, weFall, accessCol, lateWrite, earlyWrite;
  logic hiddenArm, hiddenArmNext;
  logic dataHeld, dataHeldNext;
  cycleKind_e kindNext;

  always_comb begin
    rowLow  = ~syncStrobes[IDX_ROW];
    colLow  = ~syncStrobes[IDX_COL];
    weLow   = ~syncStrobes[IDX_WE];
    oeLow   = ~syncStrobes[IDX_OE];
    rowFall = prevStrobes[IDX_ROW] & rowLow;
    colFall = prevStrobes[IDX_COL] & colLow;
    weFall  = prevStrobes[IDX_WE] & weLow;

    // a column fall counts as an access only inside an open row
    accessCol  = colFall & ~prevStrobes[IDX_ROW] & rowLow;
    earlyWrite = accessCol & weLow;
    lateWrite  = weFall & rowLow & colLow & dataHeld & ~accessCol;

    hiddenArmNext = colLow & (hiddenArm | accessCol);

    if (!colLow)        kindNext = KIND_ADDR;
    else if (hiddenArm) kindNext = KIND_HIDDEN;
    else                kindNext = KIND_CBR;

    if (!rowLow && !colLow) dataHeldNext = 1'b0;
    else if (accessCol)     dataHeldNext = ~weLow;
    else                    dataHeldNext = dataHeld;

    rowCtrl.latchRow   = rowFall;
    rowCtrl.useCounter = rowFall & colLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevStrobes <= {STROBE_W{1'b1}};
      hiddenArm   <= 1'b0;
      dataHeld    <= 1'b0;
      cycleValid  <= 1'b0;
      cycleKind   <= KIND_ADDR;
      driveEn     <= 1'b0;
      writeValid  <= 1'b0;
      writeLate   <= 1'b0;
    end else begin
      prevStrobes <= syncStrobes;
      hiddenArm   <= hiddenArmNext;
      dataHeld    <= dataHeldNext;
      cycleValid  <= rowFall;
      if (rowFall) cycleKind <= kindNext;
      driveEn     <= dataHeldNext & oeLow;
      writeValid  <= earlyWrite | lateWrite;
      if (earlyWrite | lateWrite) writeLate <= ~earlyWrite;
    end
  end

endmodule

// File: rtl/dram_refresh_path.sv
module dram_refresh_path
  import dram_dec_pkg::*;
#(
  parameter int ROWS = 2048,
  parameter int SYNC_STAGES = 2,
  localparam int ROW_BITS = $clog2(ROWS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  rowCtrl_t            rowCtrl,
  input  logic [ROW_BITS-1:0] rowAddr,
  input  logic                testMode,
  output logic [ROW_BITS-1:0] refreshRow,
  output logic [ROW_BITS-1:0] counterView
);

  localparam logic [ROW_BITS-1:0] LAST_ROW = ROW_BITS'(ROWS - 1);

  logic [ROW_BITS-1:0] addrSync;
  logic [ROW_BITS-1:0] rowCount;

  dram_sync_chain #(
    .WIDTH(ROW_BITS),
    .STAGES(SYNC_STAGES),
    .RESET_VAL('0)
  ) uAddrSync (
    .clk(clk),
    .rstN(rstN),
    .dIn(rowAddr),
    .dOut(addrSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refreshRow <= '0;
      rowCount   <= '0;
    end else if (rowCtrl.latchRow) begin
      if (rowCtrl.useCounter) begin
        refreshRow <= rowCount;
        rowCount   <= (rowCount == LAST_ROW) ? '0 : rowCount + 1'b1;
      end else begin
        refreshRow <= addrSync;
      end
    end
  end

  assign counterView = testMode ? rowCount : '0;

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dram_dec_pkg::*;
#(
  parameter int REFRESH_ROWS = 2048,
  parameter int SYNC_STAGES = 2,
  localparam int ROW_BITS = $clog2(REFRESH_ROWS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rowStrobeN,
  input  logic                colStrobeN,
  input  logic                writeEnN,
  input  logic                outEnN,
  input  logic [ROW_BITS-1:0] rowAddr,
  input  logic                testMode,
  output logic                cycleValid,
  output logic [1:0]          cycleKind,
  output logic [ROW_BITS-1:0] refreshRow,
  output logic                driveEn,
  output logic                writeValid,
  output logic                writeLate,
  output logic [ROW_BITS-1:0] counterView
);

  rowCtrl_t rowCtrl;

  dram_strobe_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .rowStrobeN(rowStrobeN),
    .colStrobeN(colStrobeN),
    .writeEnN(writeEnN),
    .outEnN(outEnN),
    .rowCtrl(rowCtrl),
    .cycleValid(cycleValid),
    .cycleKind(cycleKind),
    .driveEn(driveEn),
    .writeValid(writeValid),
    .writeLate(writeLate)
  );

  dram_refresh_path #(.ROWS(REFRESH_ROWS), .SYNC_STAGES(SYNC_STAGES)) uPath (
    .clk(clk),
    .rstN(rstN),
    .rowCtrl(rowCtrl),
    .rowAddr(rowAddr),
    .testMode(testMode),
    .refreshRow(refreshRow),
    .counterView(counterView)
  );

endmodule

// File: rtl/dram_strobe_checker.sv
module dram_strobe_checker #(
  parameter int ROWS = 2048,
  localparam int ROW_BITS = $clog2(ROWS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                testMode,
  input logic                cycleValid,
  input logic [1:0]          cycleKind,
  input logic [ROW_BITS-1:0] refreshRow,
  input logic                driveEn,
  input logic                writeValid,
  input logic                writeLate,
  input logic [ROW_BITS-1:0] counterView
);

  localparam logic [ROW_BITS-1:0] LAST_ROW = ROW_BITS'(ROWS - 1);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cycleValid |=> !cycleValid); // R2

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    cycleValid |-> cycleKind != 2'd3); // R12

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cycleValid |-> $stable(refreshRow)); // R2

  AST_CNT_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (cycleValid && cycleKind != 2'd0 && $past(testMode)) |-> refreshRow == $past(counterView)); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cycleValid && cycleKind != 2'd0 && testMode && $past(testMode)) |->
      counterView == (($past(counterView) == LAST_ROW) ? '0 : $past(counterView) + 1'b1)); // R10

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cycleValid && testMode && $past(testMode)) |-> $stable(counterView)); // R3

  AST_EARLY_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (writeValid && !writeLate) |-> !driveEn); // R7

endmodule

bind dram_strobe_decoder dram_strobe_checker #(.ROWS(REFRESH_ROWS)) uChk (
  .clk(clk),
  .rstN(rstN),
  .testMode(testMode),
  .cycleValid(cycleValid),
  .cycleKind(cycleKind),
  .refreshRow(refreshRow),
  .driveEn(driveEn),
  .writeValid(writeValid),
  .writeLate(writeLate),
  .counterView(counterView)
);

// File: tb/sim_dram_strobe_decoder.sv
`timescale 1ns/1ps
module sim_dram_strobe_decoder;

  localparam int ROWS = 2048;
  localparam int RB = 11;
  localparam int NVEC = 24;

  typedef struct packed {
    logic rowN, colN, weN, oeN;
    logic [RB-1:0] addr;
    logic expValid;
    logic [1:0] expKind;
    logic expDrive, expWv, expWl;
  } vec_t;

  // row col we oe addr | valid kind drive wv wl
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b1,1'b1,1'b0,11'h123, 1'b1,2'd0,1'b0,1'b0,1'b0}, // R2 addressed row
    '{1'b0,1'b0,1'b1,1'b0,11'h123, 1'b0,2'd0,1'b1,1'b0,1'b0}, // R5 read drives
    '{1'b0,1'b1,1'b1,1'b0,11'h123, 1'b0,2'd0,1'b1,1'b0,1'b0}, // R5 hold after col rise
    '{1'b1,1'b1,1'b1,1'b0,11'h123, 1'b0,2'd0,1'b0,1'b0,1'b0}, // R5 float after last rise
    '{1'b1,1'b0,1'b1,1'b0,11'h000, 1'b0,2'd0,1'b0,1'b0,1'b0}, // R3 col low in precharge
    '{1'b0,1'b0,1'b1,1'b0,11'h000, 1'b1,2'd1,1'b0,1'b0,1'b0}, // R3 column-before-row
    '{1'b1,1'b1,1'b1,1'b0,11'h000, 1'b0,2'd0,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,11'h055, 1'b1,2'd0,1'b0,1'b0,1'b0}, // R2
    '{1'b0,1'b0,1'b1,1'b0,11'h055, 1'b0,2'd0,1'b1,1'b0,1'b0}, // R5
    '{1'b1,1'b0,1'b1,1'b0,11'h055, 1'b0,2'd0,1'b1,1'b0,1'b0}, // R4 row up, col held
    '{1'b0,1'b0,1'b1,1'b0,11'h055, 1'b1,2'd2,1'b1,1'b0,1'b0}, // R4 hidden refresh
    '{1'b1,1'b1,1'b1,1'b0,11'h055, 1'b0,2'd0,1'b0,1'b0,1'b0}, // R5
    '{1'b0,1'b1,1'b1,1'b0,11'h2AA, 1'b1,2'd0,1'b0,1'b0,1'b0}, // R2
    '{1'b0,1'b1,1'b0,1'b0,11'h2AA, 1'b0,2'd0,1'b0,1'b0,1'b0}, // R7 we low first
    '{1'b0,1'b0,1'b0,1'b0,11'h2AA, 1'b0,2'd0,1'b0,1'b1,1'b0}, // R7 early write
    '{1'b1,1'b1,1'b1,1'b0,11'h2AA, 1'b0,2'd0,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,11'h011, 1'b1,2'd0,1'b0,1'b0,1'b0}, // R2
    '{1'b0,1'b0,1'b1,1'b0,11'h011, 1'b0,2'd0,1'b1,1'b0,1'b0}, // R5
    '{1'b0,1'b0,1'b0,1'b0,11'h011, 1'b0,2'd0,1'b1,1'b1,1'b1}, // R8 read-write
    '{1'b0,1'b0,1'b0,1'b1,11'h011, 1'b0,2'd0,1'b0,1'b0,1'b0}, // R6 oe off
    '{1'b0,1'b0,1'b0,1'b0,11'h011, 1'b0,2'd0,1'b1,1'b0,1'b0}, // R6 oe back
    '{1'b1,1'b1,1'b1,1'b0,11'h011, 1'b0,2'd0,1'b0,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,11'h400, 1'b1,2'd0,1'b0,1'b0,1'b0}, // R9 row-only
    '{1'b1,1'b1,1'b1,1'b0,11'h400, 1'b0,2'd0,1'b0,1'b0,1'b0}  // R9 no drive
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rowStrobeN = 1'b1, colStrobeN = 1'b1, writeEnN = 1'b1, outEnN = 1'b0;
  logic [RB-1:0] rowAddr = '0;
  logic testMode = 1'b1;
  logic cycleValid, driveEn, writeValid, writeLate;
  logic [1:0] cycleKind;
  logic [RB-1:0] refreshRow, counterView;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int modelCnt = 0;

  always #5 clk = ~clk;

  dram_strobe_decoder #(.REFRESH_ROWS(ROWS)) u0 (
    .clk(clk), .rstN(rstN),
    .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN),
    .writeEnN(writeEnN), .outEnN(outEnN),
    .rowAddr(rowAddr), .testMode(testMode),
    .cycleValid(cycleValid), .cycleKind(cycleKind),
    .refreshRow(refreshRow), .driveEn(driveEn),
    .writeValid(writeValid), .writeLate(writeLate),
    .counterView(counterView)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cbrCycle(output logic v, output logic [1:0] k, output logic [RB-1:0] row);
    @(negedge clk) colStrobeN = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rowStrobeN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    v = cycleValid; k = cycleKind; row = refreshRow;
    repeat (2) @(posedge clk);
    @(negedge clk) begin rowStrobeN = 1'b1; colStrobeN = 1'b1; end
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic v;
    logic [1:0] k;
    logic [RB-1:0] row;

    repeat (4) @(posedge clk);
    #1;
    chk("R1 valid in reset", int'(cycleValid), 0);
    chk("R1 drive in reset", int'(driveEn), 0);
    @(negedge clk) rstN = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 valid", int'(cycleValid), 0);
    chk("R1 drive", int'(driveEn), 0);
    chk("R1 writeValid", int'(writeValid), 0);
    chk("R1 refreshRow", int'(refreshRow), 0);
    chk("R1 counter", int'(counterView), 0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk) begin
        rowStrobeN = VEC[i].rowN; colStrobeN = VEC[i].colN;
        writeEnN = VEC[i].weN; outEnN = VEC[i].oeN; rowAddr = VEC[i].addr;
      end
      repeat (3) @(posedge clk);
      #1;
      $display("vector %0d", i);
      chk("vec valid", int'(cycleValid), int'(VEC[i].expValid));
      if (VEC[i].expValid) begin
        chk("vec kind", int'(cycleKind), int'(VEC[i].expKind));
        if (VEC[i].expKind == 2'd0) chk("vec row addr", int'(refreshRow), int'(VEC[i].addr));
        else begin
          chk("vec row counter", int'(refreshRow), modelCnt);
          modelCnt++;
        end
      end
      chk("vec driveEn", int'(driveEn), int'(VEC[i].expDrive));
      chk("vec writeValid", int'(writeValid), int'(VEC[i].expWv));
      if (VEC[i].expWv) chk("vec writeLate", int'(writeLate), int'(VEC[i].expWl));
      chk("vec counterView", int'(counterView), modelCnt);
      repeat (3) @(posedge clk);
    end

    // R11 test mode gating
    @(negedge clk) testMode = 1'b0;
    #1 chk("R11 view hidden", int'(counterView), 0);
    @(negedge clk) testMode = 1'b1;
    #1 chk("R11 view shown", int'(counterView), modelCnt);

    // R12 latency: not visible after two edges, visible after the third
    @(negedge clk) begin rowStrobeN = 1'b0; rowAddr = 11'h321; end
    repeat (2) @(posedge clk);
    #1 chk("R12 early", int'(cycleValid), 0);
    @(posedge clk);
    #1 chk("R12 third edge", int'(cycleValid), 1);
    chk("R12 row", int'(refreshRow), 'h321);
    repeat (2) @(posedge clk);
    @(negedge clk) rowStrobeN = 1'b1;
    repeat (4) @(posedge clk);

    // R10 counter wrap
    for (int n = modelCnt; n < ROWS - 1; n++) cbrCycle(v, k, row);
    #1 chk("R10 last row", int'(counterView), ROWS - 1);
    cbrCycle(v, k, row);
    chk("R10 wrap valid", int'(v), 1);
    chk("R10 wrap kind", int'(k), 1);
    chk("R10 wrap row", int'(row), ROWS - 1);
    chk("R10 wrapped", int'(counterView), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule